// File: doc/BRIEF.md
# Burst Dual-Resolution Sample Formatter

This block sits after the first decimate-by-2 stage, at half the converter clock rate, and turns the stream of 14-bit signed samples into a time-multiplexed stream whose precision changes between full 14-bit words and reduced 9-bit words. A high-resolution burst of a programmed number of samples is followed by a low-resolution stretch of another programmed number of samples. Low-resolution words are made by rounding the 14-bit value to its top 9 bits, with saturation. Each output word carries a flag that says which precision it has.

Bursts either repeat on their own (automatic mode) or are started one at a time by an external trigger pin (manual mode). In manual mode the block raises a ready output while it is waiting in low resolution. Only a rising edge of the trigger pin is accepted, and only while ready is high. Serialization of the formatted words belongs to a later stage.

Top module: `burst_res_formatter`

## Requirements
- R1: `out_valid` follows `in_valid` one clock later. After reset, `out_valid`, `out_hires` and `out_sample` are zero.
- R2: A sample taken in the high-resolution phase appears one clock later on `out_sample`, unchanged, with `out_hires` = 1.
- R3: A sample taken outside the high-resolution phase leaves with `out_hires` = 0. Its 9-bit code is floor((x + 16) / 32), limited to the range -256..255. The code sits in `out_sample[13:5]`, and `out_sample[4:0]` is zero.
- R4: In automatic mode the first valid sample after reset is low resolution. The block then repeats `cfg_hi_len` high-resolution samples followed by `cfg_lo_len` low-resolution samples. Cycles with `in_valid` low do not advance the counts.
- R5: A count of zero skips its phase. With `cfg_hi_len` = 0 every sample is low resolution, including after a manual trigger. In automatic mode, `cfg_lo_len` = 0 gives back-to-back high-resolution bursts.
- R6: In manual mode the block leaves reset in a waiting low-resolution state with `trig_ready` = 1. After a burst it returns to that state once `cfg_lo_len` low-resolution samples have passed. `trig_ready` is 0 in every other state.
- R7: In manual mode a trigger is accepted in the clock where `trig_in` is high, `trig_in` was low in the previous clock, and `trig_ready` is high. A sample presented in that same clock is still low resolution. The high-resolution burst begins with the next valid sample.
- R8: A rising edge of `trig_in` while `trig_ready` is low is ignored and is not remembered. Holding `trig_in` high starts at most one burst.
- R9: Each phase loads its length from `cfg_hi_len` or `cfg_lo_len` when the phase is entered. A change during a phase takes effect at the next entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-rate sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | 14 | Decimated signed input sample |
| cfg_hi_len | input | 8 | High-resolution samples per burst |
| cfg_lo_len | input | 8 | Low-resolution samples after each burst |
| cfg_manual | input | 1 | 1: pin-triggered bursts, 0: automatic repetition |
| trig_in | input | 1 | External burst trigger, level input, edge-detected |
| out_valid | output | 1 | Output word strobe |
| out_sample | output | 14 | Formatted word: full sample, or 9-bit code left-aligned |
| out_hires | output | 1 | 1 when the word is full resolution |
| trig_ready | output | 1 | High while a manual trigger will be accepted |

## Verification
Several properties are checked on every cycle: the one-clock valid latency, the unchanged pass-through of high-resolution words, and the zero tail of low-resolution words. The phase counter is checked to be nonzero and to step down by one per valid sample inside a burst. In manual mode, the waiting state is checked to persist until a rising trigger edge and to lead straight into a burst of the loaded length. The burst pattern over many configurations, the rounding and saturation of every possible input value, and the handling of early or held triggers and of changes to the counts mid-burst depend on long stretches of history. Only the bench scenarios can show those.

// File: rtl/brf_pkg.sv
package brf_pkg;
   typedef enum logic [1:0] {
      PH_WAIT = 2'd0,
      PH_HI   = 2'd1,
      PH_LO   = 2'd2
   } brf_phase_t;
endpackage

// File: rtl/brf_edge.sv
module brf_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic level_in,
   output logic rise
);
   logic level_q;

   always_ff @(posedge clk) begin
      if (!rst_n) level_q <= 1'b0;
      else        level_q <= level_in;
   end

   assign rise = level_in & ~level_q;
endmodule

// File: rtl/brf_lowres.sv
module brf_lowres #(
   parameter int IN_W     = 14,
   parameter int LO_W     = 9,
   parameter bit ROUND_EN = 1'b1
) (
   input  logic [IN_W-1:0] din,
   output logic [IN_W-1:0] dout
);
   localparam int DROP = IN_W - LO_W;

   if (LO_W < 2 || LO_W >= IN_W) begin : g_bad_width
      $error("brf_lowres: LO_W must lie in 2 .. IN_W-1");
   end

   logic [LO_W-1:0] code;

   if (ROUND_EN) begin : g_round
      localparam logic [IN_W:0] HALF = (IN_W+1)'(1) << (DROP - 1);
      logic [IN_W:0] ext;
      logic [IN_W:0] sum;
      logic [LO_W:0] q;
      logic          ovf;
      always_comb begin
         ext  = {din[IN_W-1], din};
         sum  = ext + HALF;
         q    = sum[IN_W:DROP];
         ovf  = q[LO_W] ^ q[LO_W-1];
         // on overflow pin to the extreme with the sign of the wide result
         code = ovf ? {q[LO_W], {(LO_W-1){~q[LO_W]}}} : q[LO_W-1:0];
      end
   end else begin : g_trunc
      assign code = din[IN_W-1:DROP];
   end

   assign dout = {code, {DROP{1'b0}}};
endmodule

// File: rtl/brf_seq.sv
module brf_seq
   import brf_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             manual,
   input  logic             trig_rise,
   input  logic [CNT_W-1:0] hi_len,
   input  logic [CNT_W-1:0] lo_len,
   output brf_phase_t       phase,
   output logic             ready
);
   if (CNT_W < 1) begin : g_bad_cnt
      $error("brf_seq: CNT_W must be at least 1");
   end

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt;
   brf_phase_t       alo_ph, ahi_ph, trg_ph, nph;
   logic [CNT_W-1:0] alo_cnt, ahi_cnt, trg_cnt, ncnt;
   logic             accept;

   // decision when a low-resolution stretch ends
   always_comb begin
      if (manual) begin
         alo_ph = PH_WAIT; alo_cnt = '0;
      end else if (hi_len != '0) begin
         alo_ph = PH_HI;   alo_cnt = hi_len;
      end else if (lo_len != '0) begin
         alo_ph = PH_LO;   alo_cnt = lo_len;
      end else begin
         alo_ph = PH_WAIT; alo_cnt = '0;
      end
   end

   // decision when a high-resolution burst ends
   always_comb begin
      if (lo_len != '0) begin
         ahi_ph = PH_LO;  ahi_cnt = lo_len;
      end else begin
         ahi_ph = alo_ph; ahi_cnt = alo_cnt;
      end
   end

   // decision on an accepted trigger
   always_comb begin
      if (hi_len != '0) begin
         trg_ph = PH_HI;  trg_cnt = hi_len;
      end else begin
         trg_ph = ahi_ph; trg_cnt = ahi_cnt;
      end
   end

   assign ready  = manual && (phase == PH_WAIT);
   assign accept = ready && trig_rise;

   always_comb begin
      nph  = phase;
      ncnt = cnt;
      if (accept) begin
         nph = trg_ph; ncnt = trg_cnt;
      end else if (in_valid) begin
         case (phase)
            PH_HI: begin
               if (cnt == ONE) begin nph = ahi_ph; ncnt = ahi_cnt; end
               else            ncnt = cnt - ONE;
            end
            PH_LO: begin
               if (cnt == ONE) begin nph = alo_ph; ncnt = alo_cnt; end
               else            ncnt = cnt - ONE;
            end
            default: begin
               if (!manual) begin nph = alo_ph; ncnt = alo_cnt; end
            end
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase <= PH_WAIT;
         cnt   <= '0;
      end else begin
         phase <= nph;
         cnt   <= ncnt;
      end
   end

   a_r4_count_live: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != PH_WAIT) |-> (cnt != '0));

   a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && phase == PH_HI && cnt > ONE) |=>
         (phase == PH_HI && cnt == $past(cnt) - ONE));

   a_r8_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_WAIT && manual && !trig_rise) |=> (phase == PH_WAIT));

   a_r7_trigger_loads: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_WAIT && manual && trig_rise && hi_len != '0) |=>
         (phase == PH_HI && cnt == $past(hi_len)));
endmodule

// File: rtl/burst_res_formatter.sv
module burst_res_formatter
   import brf_pkg::*;
#(
   parameter int IN_W     = 14,
   parameter int LO_W     = 9,
   parameter int CNT_W    = 8,
   parameter bit ROUND_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [IN_W-1:0]  in_sample,
   input  logic [CNT_W-1:0] cfg_hi_len,
   input  logic [CNT_W-1:0] cfg_lo_len,
   input  logic             cfg_manual,
   input  logic             trig_in,
   output logic             out_valid,
   output logic [IN_W-1:0]  out_sample,
   output logic             out_hires,
   output logic             trig_ready
);
   localparam int DROP = IN_W - LO_W;

   brf_phase_t      phase;
   logic            trig_rise;
   logic [IN_W-1:0] low_word;

   brf_edge u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .level_in (trig_in),
      .rise     (trig_rise)
   );

   brf_seq #(.CNT_W(CNT_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .manual    (cfg_manual),
      .trig_rise (trig_rise),
      .hi_len    (cfg_hi_len),
      .lo_len    (cfg_lo_len),
      .phase     (phase),
      .ready     (trig_ready)
   );

   brf_lowres #(.IN_W(IN_W), .LO_W(LO_W), .ROUND_EN(ROUND_EN)) u_lowres (
      .din  (in_sample),
      .dout (low_word)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_hires  <= 1'b0;
         out_sample <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_hires  <= (phase == PH_HI);
            out_sample <= (phase == PH_HI) ? in_sample : low_word;
         end
      end
   end

   a_r1_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (out_valid == $past(in_valid)));

   a_r2_high_passthru: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_hires) |-> (out_sample == $past(in_sample)));

   a_r3_low_tail_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_hires) |-> (out_sample[DROP-1:0] == '0));
endmodule

// File: tb/test_burst_res_formatter.sv
module test_burst_res_formatter;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [13:0] in_sample = '0;
   logic [3:0]  cfg_hi_len = '0;
   logic [3:0]  cfg_lo_len = '0;
   logic        cfg_manual = 1'b0;
   logic        trig_in = 1'b0;
   logic        out_valid;
   logic [13:0] out_sample;
   logic        out_hires;
   logic        trig_ready;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   burst_res_formatter #(.IN_W(14), .LO_W(9), .CNT_W(4), .ROUND_EN(1'b1)) i_burst_res_formatter (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
      .cfg_hi_len(cfg_hi_len), .cfg_lo_len(cfg_lo_len), .cfg_manual(cfg_manual),
      .trig_in(trig_in), .out_valid(out_valid), .out_sample(out_sample),
      .out_hires(out_hires), .trig_ready(trig_ready)
   );

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic [13:0] exp_low(int x);
      int t;
      t = (x + 16) >>> 5;
      if (t > 255)  t = 255;
      if (t < -256) t = -256;
      return 14'(t * 32);
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; in_valid = 1'b0; trig_in = 1'b0; in_sample = '0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R1 reset out_valid", int'(out_valid), 0);
      chk("R1 reset out_hires", int'(out_hires), 0);
      chk("R1 reset out_sample", int'(out_sample), 0);
      chk("R6 reset trig_ready", int'(trig_ready), int'(cfg_manual));
   endtask

   task automatic drive(bit v, int x, bit trig);
      @(negedge clk);
      in_valid = v; in_sample = 14'(x); trig_in = trig;
      @(posedge clk);
      #1;
   endtask

   // one manual-scenario step with expected precision and ready level
   task automatic mstep(string req, bit v, int x, bit trig, bit exp_h, bit exp_rdy);
      drive(v, x, trig);
      chk({req, " valid"}, int'(out_valid), int'(v));
      if (v) begin
         chk({req, " hires"}, int'(out_hires), int'(exp_h));
         chk({req, " sample"}, int'(out_sample), int'(exp_h ? 14'(x) : exp_low(x)));
      end
      chk({req, " ready"}, int'(trig_ready), int'(exp_rdy));
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      // R4 / R5: automatic pattern over every small count pair
      for (int hi = 0; hi <= 4; hi++) begin
         for (int lo = 0; lo <= 4; lo++) begin
            int k;
            int per;
            string rq;
            cfg_manual = 1'b0;
            cfg_hi_len = 4'(hi);
            cfg_lo_len = 4'(lo);
            do_reset();
            k = 0;
            per = hi + lo;
            rq = (hi == 0 || lo == 0) ? "R5" : "R4";
            for (int s = 0; s < 24; s++) begin
               if (s % 4 == 3) begin
                  drive(1'b0, 0, 1'b0);
                  chk("R1 gap no valid", int'(out_valid), 0);
               end else begin
                  int x;
                  bit eh;
                  x = ((hi * 977 + lo * 137 + s * 611) % 16384) - 8192;
                  eh = (k == 0 || per == 0) ? 1'b0 : (((k - 1) % per) < hi);
                  drive(1'b1, x, 1'b0);
                  chk("R1 valid", int'(out_valid), 1);
                  chk({rq, " precision"}, int'(out_hires), int'(eh));
                  chk(eh ? "R2 passthru" : "R3 lowres", int'(out_sample),
                      int'(eh ? 14'(x) : exp_low(x)));
                  chk("R6 auto no ready", int'(trig_ready), 0);
                  k++;
               end
            end
         end
      end

      // R3: every input value through the low-resolution path
      cfg_manual = 1'b0; cfg_hi_len = 4'd0; cfg_lo_len = 4'd1;
      do_reset();
      for (int x = -8192; x <= 8191; x++) begin
         drive(1'b1, x, 1'b0);
         chk("R3 sweep", int'(out_sample), int'(exp_low(x)));
      end
      chk("R3 sweep flag", int'(out_hires), 0);

      // R9: length change inside a burst applies at the next entry
      cfg_manual = 1'b0; cfg_hi_len = 4'd2; cfg_lo_len = 4'd2;
      do_reset();
      mstep("R9 first", 1'b1, 100, 1'b0, 1'b0, 1'b0);
      cfg_hi_len = 4'd4;
      mstep("R9 old burst", 1'b1, 101, 1'b0, 1'b1, 1'b0);
      mstep("R9 old burst", 1'b1, 102, 1'b0, 1'b1, 1'b0);
      mstep("R9 low", 1'b1, 103, 1'b0, 1'b0, 1'b0);
      mstep("R9 low", 1'b1, 104, 1'b0, 1'b0, 1'b0);
      for (int i = 0; i < 4; i++) mstep("R9 new burst", 1'b1, 105 + i, 1'b0, 1'b1, 1'b0);
      mstep("R9 low after", 1'b1, 109, 1'b0, 1'b0, 1'b0);

      // R6 / R7 / R8: manual triggering
      cfg_manual = 1'b1; cfg_hi_len = 4'd3; cfg_lo_len = 4'd2;
      do_reset();
      for (int i = 0; i < 3; i++) mstep("R6 waiting", 1'b1, -300 + i, 1'b0, 1'b0, 1'b1);
      mstep("R7 trigger no sample", 1'b0, 0, 1'b1, 1'b0, 1'b0);
      for (int i = 0; i < 3; i++) mstep("R7 burst", 1'b1, 1200 + i, 1'b1, 1'b1, 1'b0);
      mstep("R6 guard low", 1'b1, 700, 1'b0, 1'b0, 1'b0);
      mstep("R8 early edge", 1'b1, 701, 1'b1, 1'b0, 1'b1);
      for (int i = 0; i < 3; i++) mstep("R8 early edge ignored", 1'b1, 702 + i, 1'b1, 1'b0, 1'b1);
      mstep("R7 release", 1'b1, 710, 1'b0, 1'b0, 1'b1);
      mstep("R7 edge with sample", 1'b1, 711, 1'b1, 1'b0, 1'b0);
      for (int i = 0; i < 3; i++) mstep("R7 second burst", 1'b1, -4000 + i, 1'b1, 1'b1, 1'b0);
      mstep("R8 held guard", 1'b1, 50, 1'b1, 1'b0, 1'b0);
      mstep("R8 held guard end", 1'b1, 51, 1'b1, 1'b0, 1'b1);
      for (int i = 0; i < 4; i++) mstep("R8 held one burst", 1'b1, 52 + i, 1'b1, 1'b0, 1'b1);

      // R5: zero high count under manual trigger
      cfg_manual = 1'b1; cfg_hi_len = 4'd0; cfg_lo_len = 4'd2;
      do_reset();
      mstep("R5 zero burst trigger", 1'b0, 0, 1'b1, 1'b0, 1'b0);
      mstep("R5 zero burst low", 1'b1, 8191, 1'b1, 1'b0, 1'b0);
      mstep("R5 zero burst back", 1'b1, -8192, 1'b0, 1'b0, 1'b1);

      finish_run();
   end
endmodule